// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one eight-pin general-purpose I/O port from a processor's special-function-register bus. Software sets three registers. The output latch holds the value each pin should drive. The pin-mode register marks each pin as analog or digital. The drive-style register marks each pin as push-pull or open-drain. From these three registers the block produces four signals per pin for the pad ring: a driver enable, a driver value, a weak pull-up enable and a digital receiver enable.

Reading the latch address returns the live pin levels, not the stored latch. The pins pass through a two-flop synchronizer first, and any pin in analog mode reads as zero. The latch also accepts single-bit writes. A single-bit write changes one latch bit and takes every other bit from the latch contents. A pin held low by an external device therefore cannot corrupt the stored value.

An asynchronous active-low reset clears the block. The reset is released synchronously inside the block.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the latch holds all ones and the pin-mode register holds all ones (all pins digital). The drive-style register holds all zeros (all pins open-drain). Reads of the pin-mode address (0xF4) return 0xFF and reads of the drive-style address (0xA7) return 0x00.
- R2: When sfr_wr is high, sfr_wdata is stored on the next rising clock edge into the register selected by sfr_addr: latch 0xB0, pin-mode 0xF4, drive-style 0xA7. A later read of 0xF4 or 0xA7 returns the stored byte.
- R3: When bit_wr is high, sfr_wr is low and sfr_addr is 0xB0, only latch bit bit_sel takes bit_val, and the other latch bits keep their stored values whatever the pin levels are. When sfr_wr and bit_wr are both high, the byte write wins and bit_wr is ignored.
- R4: A digital pin whose latch bit is 0 has pad_oe=1 and pad_out=0, in either drive style. pad_out is 0 whenever pad_oe is 0.
- R5: A digital push-pull pin (drive-style bit 1) whose latch bit is 1 has pad_oe=1, pad_out=1 and pad_pu=0.
- R6: A digital open-drain pin (drive-style bit 0) whose latch bit is 1 has pad_oe=0 and pad_pu=1. pad_pu and pad_oe are never both high on the same pin.
- R7: An analog pin (pin-mode bit 0) has pad_oe, pad_pu and pad_rx all 0, whatever its latch bit and drive-style bit are.
- R8: A digital pin has pad_rx=1. A digital pin with latch bit 0 has pad_pu=0.
- R9: A read of 0xB0 returns the pin levels sampled through two flops. A change on pin_in is not visible after one rising edge and is visible after two. Bits of analog pins read as 0.
- R10: A write or bit write to any address other than the three mapped ones changes no register. A read of such an address returns 0, and sfr_rdata is 0 whenever sfr_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sfr_addr_i | input | 8 | Register address |
| sfr_wr_i | input | 1 | Byte write strobe |
| sfr_wdata_i | input | 8 | Byte write data |
| bit_wr_i | input | 1 | Single-bit write strobe for the latch |
| bit_sel_i | input | 3 | Index of the latch bit to write |
| bit_val_i | input | 1 | Value of the latch bit to write |
| sfr_rd_i | input | 1 | Read strobe |
| sfr_rdata_o | output | 8 | Read data (combinational) |
| pin_in_i | input | 8 | Pin levels from the pads |
| pad_oe_o | output | 8 | Per-pin driver enable |
| pad_out_o | output | 8 | Per-pin driver value |
| pad_pu_o | output | 8 | Per-pin weak pull-up enable |
| pad_rx_o | output | 8 | Per-pin digital receiver enable |

## Verification
The embedded assertions check register behaviour on every cycle: byte writes landing, single-bit writes touching only the addressed bit, and unmapped accesses leaving all state alone. They also check that analog pins never enable a driver, pull-up or receiver, that the pull-up and driver never coincide, that the drive value is quiet when the driver is off, and that analog bits read as zero. The bench's scenarios cover the rest. They show the reset values and the per-pin results of each mode combination. They show the exact two-edge synchronizer latency. They show that a bit write builds on the latch while the pins are held low, and that a byte write takes priority over a simultaneous bit write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PIN_COUNT  = 8;
  localparam int unsigned ADDR_WIDTH = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  localparam logic [ADDR_WIDTH-1:0] ADDR_LATCH = 8'hB0;
  localparam logic [ADDR_WIDTH-1:0] ADDR_PMODE = 8'hF4;
  localparam logic [ADDR_WIDTH-1:0] ADDR_DMODE = 8'hA7;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_PMODE = 2'd2,
    SEL_DMODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_comb begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned           N       = 8,
  parameter int unsigned           AW      = 8,
  parameter logic [AW-1:0]         A_LATCH = 8'hB0,
  parameter logic [AW-1:0]         A_PMODE = 8'hF4,
  parameter logic [AW-1:0]         A_DMODE = 8'hA7,
  parameter logic [N-1:0]          RST_LATCH = '1,
  parameter logic [N-1:0]          RST_PMODE = '1,
  parameter logic [N-1:0]          RST_DMODE = '0,
  localparam int unsigned          SW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic          bit_wr_i,
  input  logic [SW-1:0] bit_sel_i,
  input  logic          bit_val_i,
  output logic [N-1:0]  latch_o,
  output logic [N-1:0]  pmode_o,
  output logic [N-1:0]  dmode_o
);
  localparam logic [N-1:0] ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};

  reg_sel_e     sel;
  logic [N-1:0] latch_q, latch_d;
  logic [N-1:0] pmode_q, pmode_d;
  logic [N-1:0] dmode_q, dmode_d;
  logic         latch_en, pmode_en, dmode_en;

  always_comb begin
    if (addr_i == A_LATCH)      sel = SEL_LATCH;
    else if (addr_i == A_PMODE) sel = SEL_PMODE;
    else if (addr_i == A_DMODE) sel = SEL_DMODE;
    else                        sel = SEL_NONE;
  end

  always_comb begin
    latch_d  = latch_q;
    pmode_d  = pmode_q;
    dmode_d  = dmode_q;
    latch_en = 1'b0;
    pmode_en = 1'b0;
    dmode_en = 1'b0;
    if (wr_i) begin
      unique case (sel)
        SEL_LATCH: begin latch_d = wdata_i; latch_en = 1'b1; end
        SEL_PMODE: begin pmode_d = wdata_i; pmode_en = 1'b1; end
        SEL_DMODE: begin dmode_d = wdata_i; dmode_en = 1'b1; end
        default:   ;
      endcase
    end else if (bit_wr_i && (sel == SEL_LATCH)) begin
      latch_d[bit_sel_i] = bit_val_i;
      latch_en           = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= RST_LATCH;
      pmode_q <= RST_PMODE;
      dmode_q <= RST_DMODE;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (pmode_en) pmode_q <= pmode_d;
      if (dmode_en) dmode_q <= dmode_d;
    end
  end

  assign latch_o = latch_q;
  assign pmode_o = pmode_q;
  assign dmode_o = dmode_q;

  // R2
  byte_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_PMODE) |=> (pmode_q == $past(wdata_i)));

  // R3
  bit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_wr_i && !wr_i && addr_i == A_LATCH) |=>
      ((((latch_q ^ $past(latch_q)) & ~(ONE_HOT0 << $past(bit_sel_i))) == '0) &&
       (latch_q[$past(bit_sel_i)] == $past(bit_val_i))));

  // R10
  unmapped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != A_LATCH && addr_i != A_PMODE && addr_i != A_DMODE) |=>
      ($stable(latch_q) && $stable(pmode_q) && $stable(dmode_q)));
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell (
  input  logic latch_i,
  input  logic digital_i,
  input  logic push_pull_i,
  output logic oe_o,
  output logic out_o,
  output logic pu_o,
  output logic rx_o
);
  logic drive_low;
  logic drive_high;

  always_comb begin
    drive_low  = digital_i && !latch_i;
    drive_high = digital_i && latch_i && push_pull_i;
    oe_o       = drive_low || drive_high;
    out_o      = drive_high;
    pu_o       = digital_i && latch_i && !push_pull_i;
    rx_o       = digital_i;
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux #(
  parameter int unsigned   N       = 8,
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] A_LATCH = 8'hB0,
  parameter logic [AW-1:0] A_PMODE = 8'hF4,
  parameter logic [AW-1:0] A_DMODE = 8'hA7
) (
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  pin_sync_i,
  input  logic [N-1:0]  pmode_i,
  input  logic [N-1:0]  dmode_i,
  output logic [N-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == A_LATCH)      rdata_o = pin_sync_i & pmode_i;
      else if (addr_i == A_PMODE) rdata_o = pmode_i;
      else if (addr_i == A_DMODE) rdata_o = dmode_i;
      else                        rdata_o = '0;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned           N_PINS  = PIN_COUNT,
  parameter int unsigned           AW      = ADDR_WIDTH,
  parameter int unsigned           SYNC_N  = SYNC_DEPTH,
  parameter logic [ADDR_WIDTH-1:0] A_LATCH = ADDR_LATCH,
  parameter logic [ADDR_WIDTH-1:0] A_PMODE = ADDR_PMODE,
  parameter logic [ADDR_WIDTH-1:0] A_DMODE = ADDR_DMODE
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             sfr_addr_i,
  input  logic                      sfr_wr_i,
  input  logic [N_PINS-1:0]         sfr_wdata_i,
  input  logic                      bit_wr_i,
  input  logic [$clog2(N_PINS)-1:0] bit_sel_i,
  input  logic                      bit_val_i,
  input  logic                      sfr_rd_i,
  output logic [N_PINS-1:0]         sfr_rdata_o,
  input  logic [N_PINS-1:0]         pin_in_i,
  output logic [N_PINS-1:0]         pad_oe_o,
  output logic [N_PINS-1:0]         pad_out_o,
  output logic [N_PINS-1:0]         pad_pu_o,
  output logic [N_PINS-1:0]         pad_rx_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [N_PINS-1:0] latch_q, pmode_q, dmode_q, pin_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  gpio_regs #(
    .N(N_PINS), .AW(AW),
    .A_LATCH(A_LATCH), .A_PMODE(A_PMODE), .A_DMODE(A_DMODE)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .addr_i    (sfr_addr_i),
    .wr_i      (sfr_wr_i),
    .wdata_i   (sfr_wdata_i),
    .bit_wr_i  (bit_wr_i),
    .bit_sel_i (bit_sel_i),
    .bit_val_i (bit_val_i),
    .latch_o   (latch_q),
    .pmode_o   (pmode_q),
    .dmode_o   (dmode_q)
  );

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_N)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .async_i (pin_in_i),
    .sync_o  (pin_sync)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    gpio_pad_cell i_cell (
      .latch_i     (latch_q[p]),
      .digital_i   (pmode_q[p]),
      .push_pull_i (dmode_q[p]),
      .oe_o        (pad_oe_o[p]),
      .out_o       (pad_out_o[p]),
      .pu_o        (pad_pu_o[p]),
      .rx_o        (pad_rx_o[p])
    );
  end

  gpio_rd_mux #(
    .N(N_PINS), .AW(AW),
    .A_LATCH(A_LATCH), .A_PMODE(A_PMODE), .A_DMODE(A_DMODE)
  ) i_rd_mux (
    .rd_i       (sfr_rd_i),
    .addr_i     (sfr_addr_i),
    .pin_sync_i (pin_sync),
    .pmode_i    (pmode_q),
    .dmode_i    (dmode_q),
    .rdata_o    (sfr_rdata_o)
  );

  // R7
  analog_off_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((pad_oe_o | pad_pu_o | pad_rx_o) & ~pmode_q) == '0);

  // R6
  pu_drive_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (pad_pu_o & pad_oe_o) == '0);

  // R4
  quiet_value_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (pad_out_o & ~pad_oe_o) == '0);

  // R9
  analog_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (sfr_rd_i && sfr_addr_i == A_LATCH) |-> ((sfr_rdata_o & ~pmode_q) == '0));

  // R10
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !sfr_rd_i |-> (sfr_rdata_o == '0));
endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr, wdata, rdata, pins;
  logic       wr, bwr, bval, rd;
  logic [2:0] bsel;
  logic [7:0] oe, dout, pu, rx;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_wdata_i(wdata),
    .bit_wr_i(bwr), .bit_sel_i(bsel), .bit_val_i(bval),
    .sfr_rd_i(rd), .sfr_rdata_o(rdata), .pin_in_i(pins),
    .pad_oe_o(oe), .pad_out_o(dout), .pad_pu_o(pu), .pad_rx_o(rx)
  );

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bit_write(input logic [7:0] a, input logic [2:0] s, input logic v);
    @(negedge clk);
    addr = a; bsel = s; bval = v; bwr = 1'b1;
    @(negedge clk);
    bwr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  // Expected pad outputs from R4..R8 for given latch, pin-mode, drive-style.
  task automatic check_pads(input string req, input logic [7:0] l,
                            input logic [7:0] m, input logic [7:0] s);
    logic [7:0] e_oe, e_pu;
    e_oe = m & (~l | (l & s));
    e_pu = m & l & ~s;
    #1;
    check8(req, "pad_oe",  oe,   e_oe);
    check8(req, "pad_out", dout, m & l & s);
    check8(req, "pad_pu",  pu,   e_pu);
    check8(req, "pad_rx",  rx,   m);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    sfr_read(8'hF4, v); check8("R1", "pmode reset", v, 8'hFF);
    sfr_read(8'hA7, v); check8("R1", "dmode reset", v, 8'h00);
    check_pads("R1", 8'hFF, 8'hFF, 8'h00);
  endtask

  task automatic t_push_pull;
    logic [7:0] v;
    sfr_write(8'hA7, 8'hFF);
    sfr_read(8'hA7, v); check8("R2", "dmode readback", v, 8'hFF);
    check_pads("R5", 8'hFF, 8'hFF, 8'hFF);
    sfr_write(8'hB0, 8'h0F);
    check_pads("R4", 8'h0F, 8'hFF, 8'hFF);
  endtask

  task automatic t_open_drain;
    sfr_write(8'hA7, 8'h00);
    check_pads("R6", 8'h0F, 8'hFF, 8'h00);
    sfr_write(8'hA7, 8'h33);
    check_pads("R8", 8'h0F, 8'hFF, 8'h33);
  endtask

  task automatic t_analog;
    logic [7:0] v;
    sfr_write(8'hF4, 8'h3C ^ 8'hFF);
    sfr_read(8'hF4, v); check8("R2", "pmode readback", v, 8'hC3);
    check_pads("R7", 8'h0F, 8'hC3, 8'h33);
    sfr_write(8'hA7, 8'hFF);
    check_pads("R7", 8'h0F, 8'hC3, 8'hFF);
  endtask

  task automatic t_pin_read;
    logic [7:0] v;
    @(negedge clk);
    pins = 8'hA5;
    sfr_read(8'hB0, v); check8("R9", "after one edge", v, 8'h00);
    sfr_read(8'hB0, v); check8("R9", "after two edges", v, 8'hA5 & 8'hC3);
    sfr_write(8'hF4, 8'hFF);
    sfr_read(8'hB0, v); check8("R9", "all digital", v, 8'hA5);
  endtask

  task automatic t_bit_ops;
    pins = 8'h00;
    sfr_write(8'hA7, 8'h00);
    sfr_write(8'hB0, 8'h0F);
    bit_write(8'hB0, 3'd6, 1'b1);
    bit_write(8'hB0, 3'd0, 1'b0);
    sfr_write(8'hA7, 8'hFF);
    check_pads("R3", 8'h4E, 8'hFF, 8'hFF);
    @(negedge clk);
    addr = 8'hB0; wdata = 8'h11; wr = 1'b1; bwr = 1'b1; bsel = 3'd7; bval = 1'b1;
    @(negedge clk);
    wr = 1'b0; bwr = 1'b0;
    check_pads("R3", 8'h11, 8'hFF, 8'hFF);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    sfr_write(8'h80, 8'h00);
    bit_write(8'h80, 3'd0, 1'b0);
    sfr_write(8'hB1, 8'hAA);
    check_pads("R10", 8'h11, 8'hFF, 8'hFF);
    sfr_read(8'hF4, v); check8("R10", "pmode kept", v, 8'hFF);
    sfr_read(8'hA7, v); check8("R10", "dmode kept", v, 8'hFF);
    sfr_read(8'h80, v); check8("R10", "unmapped read", v, 8'h00);
    @(negedge clk);
    addr = 8'hF4; rd = 1'b0;
    #1 check8("R10", "idle rdata", rdata, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; bwr = 1'b0;
    bsel = '0; bval = 1'b0; rd = 1'b0; pins = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_push_pull();
    t_open_drain();
    t_analog();
    t_pin_read();
    t_bit_ops();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule